// File: doc/BRIEF.md
# Asynchronous Timer Register Update Tracker

This block sits between a system-clock register interface and a timer whose clock can be taken from a separate, free-running oscillator. Software writes the timer's count, compare and control registers from the system side. When the timer runs from the oscillator, each write is first captured in a system-side holding register. It is then carried into the oscillator domain by a toggle handshake. A per-register busy flag stays raised until the timer-domain copy has been loaded and the acknowledge has come back. Software polls that flag to learn when the register can take another value.

A status byte shows the clock-select bit and the three busy flags. When the clock-select bit is zero, the timer runs from the system clock: writes land at once, and the busy flags never rise. The view outputs give the values the timer logic should use. In oscillator mode these are the timer-domain copies; in system mode they are the system-side holding registers. The counting logic itself is not part of this block. After the clock-select bit changes, software must rewrite any register whose value it relies on, because the copy in the newly selected domain may be stale.

Top module: `tmr_async_upd`

## Requirements
- R1: Bits 7 to 4 of the status byte always read as zero.
- R2: A write to address 0 loads status bit 3 (clock select, 1 = oscillator clock, 0 = system clock) from `wr_data[3]`. All other data bits of that write are ignored, and bit 3 reads back as written.
- R3: After reset, the status byte, all three view outputs and `rd_data` are zero.
- R4: The busy flags are at status bit 2 for the count register (address 1), bit 1 for the compare register (address 2) and bit 0 for the control register (address 3). A write to one register leaves the other two flags unchanged.
- R5: With clock select at 1, a write to a register whose busy flag is 0 raises that flag in the next system-clock cycle.
- R6: A busy flag falls only once the oscillator-domain copy holds the written value. From that cycle on, the view output for that register (clock select 1) shows the value.
- R7: A write to a register whose busy flag is 1 is ignored. The held value and the value finally delivered to the timer domain are those of the earlier write.
- R8: With clock select at 0, a write to an idle register appears on its view output in the next system-clock cycle, and its busy flag stays 0.
- R9: `rd_en` returns data on `rd_data` one system-clock cycle later. Address 0 returns the status byte. Addresses 1 to 3 return the most recently accepted value for that register, even while its transfer is still pending.
- R10: With clock select at 1, the view outputs show the oscillator-domain copies, including stale ones from before a mode change. With clock select at 0, they show the system-side holding registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the register interface |
| clk_tmr | input | 1 | Oscillator clock for the timer domain |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 status, 1 count, 2 compare, 3 control |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Registered read data |
| status_o | output | 8 | Status byte: clock select and three busy flags |
| count_o | output | 8 | Count register value seen by the timer |
| compare_o | output | 8 | Compare register value seen by the timer |
| control_o | output | 8 | Control register value seen by the timer |

## Verification
The bound checker watches the handshake on every system-clock cycle. It checks that the reserved status bits stay zero, that an accepted write in oscillator mode raises the right busy flag, and that a write in system mode leaves it low. It also checks that a write to a busy register leaves the held value untouched, and that a flag only falls once the timer-domain copy matches the held value. The bench scenarios show what the properties cannot. These are the reset values, the read-back path, the exact status encodings after mixed writes to several registers, stale timer copies appearing after a mode switch, and the final delivered value after a rejected write.

// File: rtl/tmr_upd_pkg.sv
package tmr_upd_pkg;
  localparam int NUM_CH  = 3;
  localparam int SEL_BIT = 3;

  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_CTL  = 2'd3
  } reg_addr_e;

  // channel 0 = count, 1 = compare, 2 = control
  function automatic logic [1:0] ch_addr(input int ch);
    return 2'(ch + 1);
  endfunction

  // busy flag position in the status byte
  function automatic int ch_stat_bit(input int ch);
    return NUM_CH - 1 - ch;
  endfunction
endpackage

// File: rtl/tmr_sync_bit.sv
module tmr_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tmr_upd_channel.sv
module tmr_upd_channel #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              clk_tmr,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              async_mode,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy_o,
  output logic [DATA_W-1:0] shadow_o,
  output logic [DATA_W-1:0] tmr_val_o
);
  logic              req_tgl;
  logic              ack_s;
  logic              busy_q;
  logic [DATA_W-1:0] shadow_q;
  logic              req_s;
  logic              seen_q;
  logic [DATA_W-1:0] tmr_q;

  // system domain: holding register, request toggle, busy flag
  always_ff @(posedge clk_sys) begin
    if (rst) begin
      shadow_q <= '0;
      req_tgl  <= 1'b0;
      busy_q   <= 1'b0;
    end else if (wr_hit && !busy_q) begin
      shadow_q <= wr_data;
      if (async_mode) begin
        req_tgl <= ~req_tgl;
        busy_q  <= 1'b1;
      end
    end else if (busy_q && (ack_s == req_tgl)) begin
      busy_q <= 1'b0;
    end
  end

  tmr_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (clk_tmr),
    .rst (rst),
    .d   (req_tgl),
    .q   (req_s)
  );

  // timer domain: load copy when a new request toggle arrives
  always_ff @(posedge clk_tmr) begin
    if (rst) begin
      tmr_q  <= '0;
      seen_q <= 1'b0;
    end else if (req_s != seen_q) begin
      tmr_q  <= shadow_q;
      seen_q <= req_s;
    end
  end

  tmr_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk_sys),
    .rst (rst),
    .d   (seen_q),
    .q   (ack_s)
  );

  assign busy_o    = busy_q;
  assign shadow_o  = shadow_q;
  assign tmr_val_o = tmr_q;
endmodule

// File: rtl/tmr_async_upd.sv
module tmr_async_upd #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              clk_tmr,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] compare_o,
  output logic [DATA_W-1:0] control_o
);
  import tmr_upd_pkg::*;

  localparam int RSV_W = DATA_W - SEL_BIT - 1;

  logic                           sel_q;
  logic [NUM_CH-1:0]              wr_hit;
  logic [NUM_CH-1:0]              busy_v;
  logic [NUM_CH-1:0][DATA_W-1:0]  shadow_v;
  logic [NUM_CH-1:0][DATA_W-1:0]  tmr_v;
  logic [NUM_CH-1:0][DATA_W-1:0]  view_v;
  logic [SEL_BIT-1:0]             busy_stat;

  always_ff @(posedge clk_sys) begin
    if (rst)                                     sel_q <= 1'b0;
    else if (wr_en && wr_addr == ADDR_STAT)      sel_q <= wr_data[SEL_BIT];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_hit[c] = wr_en && (wr_addr == ch_addr(c));

    tmr_upd_channel #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_chan (
      .clk_sys    (clk_sys),
      .clk_tmr    (clk_tmr),
      .rst        (rst),
      .wr_hit     (wr_hit[c]),
      .async_mode (sel_q),
      .wr_data    (wr_data),
      .busy_o     (busy_v[c]),
      .shadow_o   (shadow_v[c]),
      .tmr_val_o  (tmr_v[c])
    );

    assign busy_stat[ch_stat_bit(c)] = busy_v[c];
    assign view_v[c] = sel_q ? tmr_v[c] : shadow_v[c];
  end

  assign status_o  = {{RSV_W{1'b0}}, sel_q, busy_stat};
  assign count_o   = view_v[0];
  assign compare_o = view_v[1];
  assign control_o = view_v[2];

  always_ff @(posedge clk_sys) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= status_o;
      for (int c = 0; c < NUM_CH; c++) begin
        if (rd_addr == ch_addr(c)) rd_data <= shadow_v[c];
      end
    end
  end
endmodule

// File: rtl/tmr_async_upd_chk.sv
module tmr_async_upd_chk #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 3
) (
  input logic                          clk_sys,
  input logic                          rst,
  input logic                          sel_q,
  input logic [NUM_CH-1:0]             wr_hit,
  input logic [NUM_CH-1:0]             busy_v,
  input logic [DATA_W-1:0]             status_o,
  input logic [NUM_CH-1:0][DATA_W-1:0] shadow_v,
  input logic [NUM_CH-1:0][DATA_W-1:0] tmr_v
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk_sys) disable iff (rst)
    status_o[DATA_W-1:4] == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    busy_rise_chk: assert property (@(posedge clk_sys) disable iff (rst)
      (wr_hit[c] && sel_q && !busy_v[c]) |=> busy_v[c]);

    // R8
    sync_no_busy_chk: assert property (@(posedge clk_sys) disable iff (rst)
      (wr_hit[c] && !sel_q && !busy_v[c]) |=> !busy_v[c]);

    // R7
    busy_ignore_chk: assert property (@(posedge clk_sys) disable iff (rst)
      (wr_hit[c] && busy_v[c]) |=> $stable(shadow_v[c]));

    // R6
    clear_match_chk: assert property (@(posedge clk_sys) disable iff (rst)
      $fell(busy_v[c]) |-> (tmr_v[c] == shadow_v[c]));
  end
endmodule

bind tmr_async_upd tmr_async_upd_chk #(
  .DATA_W (DATA_W),
  .NUM_CH (tmr_upd_pkg::NUM_CH)
) u_chk (
  .clk_sys  (clk_sys),
  .rst      (rst),
  .sel_q    (sel_q),
  .wr_hit   (wr_hit),
  .busy_v   (busy_v),
  .status_o (status_o),
  .shadow_v (shadow_v),
  .tmr_v    (tmr_v)
);

// File: tb/tmr_async_upd_bench.sv
module tmr_async_upd_bench;
  logic       clk_sys = 1'b0;
  logic       clk_tmr = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data, status_o, count_o, compare_o, control_o;

  int total = 0;
  int bad   = 0;

  always #10 clk_sys = ~clk_sys;   // 50 MHz
  always #31 clk_tmr = ~clk_tmr;   // unrelated oscillator

  tmr_async_upd u_tmr_async_upd (
    .clk_sys   (clk_sys),
    .clk_tmr   (clk_tmr),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .status_o  (status_o),
    .count_o   (count_o),
    .compare_o (compare_o),
    .control_o (control_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_sys);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_sys);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_sys);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk_sys);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while ((status_o[2:0] != 3'b000) && n < 200) begin
      @(negedge clk_sys);
      n++;
    end
    chk({tag, " busy clears"}, 8'(status_o[2:0] != 3'b000), 8'h00);
  endtask

  task automatic t_reset;
    chk("R3 status", status_o, 8'h00);
    chk("R3 count", count_o, 8'h00);
    chk("R3 compare", compare_o, 8'h00);
    chk("R3 control", control_o, 8'h00);
    chk("R3 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_status_write;
    wr(2'd0, 8'hFF);
    chk("R1 R2 select set, reserved zero", status_o, 8'h08);
    wr(2'd0, 8'hF7);
    chk("R2 select cleared", status_o, 8'h00);
  endtask

  task automatic t_sync_write;
    wr(2'd1, 8'h5A);
    chk("R8 count direct", count_o, 8'h5A);
    chk("R8 no busy", status_o, 8'h00);
    wr(2'd2, 8'h33);
    wr(2'd3, 8'hC1);
    chk("R8 compare direct", compare_o, 8'h33);
    chk("R8 control direct", control_o, 8'hC1);
    chk("R8 still idle", status_o, 8'h00);
  endtask

  task automatic t_async_write;
    wr(2'd0, 8'h08);
    chk("R10 stale timer copy shown", count_o, 8'h00);
    wr(2'd1, 8'hA5);
    chk("R5 R4 count busy bit2", status_o, 8'h0C);
    chk("R6 not yet delivered", count_o, 8'h00);
    wait_idle("R6");
    chk("R6 delivered", count_o, 8'hA5);
    chk("R6 status idle", status_o, 8'h08);
  endtask

  task automatic t_ignore;
    logic [7:0] v;
    wr(2'd2, 8'h11);
    wr(2'd2, 8'h22);
    chk("R5 R4 compare busy bit1", status_o, 8'h0A);
    rd(2'd2, v);
    chk("R7 R9 held value kept", v, 8'h11);
    wait_idle("R7");
    chk("R7 delivered first value", compare_o, 8'h11);
  endtask

  task automatic t_independent;
    wr(2'd3, 8'h7E);
    chk("R4 control busy bit0", status_o, 8'h09);
    chk("R4 count untouched", count_o, 8'hA5);
    wr(2'd1, 8'h3C);
    chk("R4 two flags", status_o, 8'h0D);
    wait_idle("R4");
    chk("R4 count delivered", count_o, 8'h3C);
    chk("R4 control delivered", control_o, 8'h7E);
    chk("R4 compare untouched", compare_o, 8'h11);
  endtask

  task automatic t_read;
    logic [7:0] v;
    rd(2'd0, v);
    chk("R9 read status", v, 8'h08);
    rd(2'd1, v);
    chk("R9 read count", v, 8'h3C);
    wr(2'd1, 8'h96);
    rd(2'd1, v);
    chk("R9 read pending value", v, 8'h96);
    wait_idle("R9");
  endtask

  task automatic t_back_sync;
    wr(2'd0, 8'h00);
    chk("R10 system copy shown", control_o, 8'h7E);
    wr(2'd3, 8'h44);
    chk("R8 control direct again", control_o, 8'h44);
    chk("R8 no busy again", status_o, 8'h00);
  endtask

  initial begin
    repeat (6) @(negedge clk_sys);
    rst = 1'b0;
    @(negedge clk_sys);
    t_reset();
    t_status_write();
    t_sync_write();
    t_async_write();
    t_ignore();
    t_independent();
    t_read();
    t_back_sync();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_sys);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule